// File: doc/BRIEF.md
# Autovectored Interrupt Vector Inserter

This block sits in the code-fetch path of an 8-bit processor and serves fourteen interrupt request lines from the FIFO and waveform-engine logic. A fixed priority order resolves the requests. When the processor acknowledges the interrupt, the block latches the winning source. The processor's interrupt entry point is a three-byte jump stub: the opcode at 0x553, the page (high) byte at 0x554 and the low byte at 0x555. When autovectoring is enabled, the block replaces the byte fetched from 0x555 with a vector byte for the latched source. The jump then lands on one of fourteen four-byte-spaced entries in a jump table. Firmware places that table on the page named by 0x554.

The request lines are numbered by priority, and bit 0 is the highest. Bits 0..3 are the programmable-level flags of FIFO endpoints 2, 4, 6 and 8. Bits 4..7 are the empty flags of those endpoints, in the same endpoint order. Bits 8..11 are their full flags. Bit 12 is waveform operation done, and bit 13 is the waveform event. Every output is registered, so each one reflects the inputs of the previous clock.

Top module: `irq_vector_splicer`

## Requirements
- R1: While `rst` is high, `fetch_data_o`, `irq_any_o` and `src_sel_o` are all zero from the next clock edge onward.
- R2: `irq_any_o` equals the OR of all fourteen `irq_req_i` bits sampled at the previous clock edge.
- R3: On a clock edge where `irq_ack_i` is high and at least one request is set, the index of the lowest-numbered set request bit (0 = highest priority, 13 = lowest) is latched and appears on `src_sel_o` after that edge.
- R4: When `irq_ack_i` is low, `src_sel_o` and the latched source keep their value, whatever the request lines do.
- R5: A code fetch (`code_fetch_i` high) of address 0x555 with `avec_en_i` high and a latched valid source returns, one cycle later on `fetch_data_o`, the byte 0x80 + 4*index (0x80 for index 0 up to 0xB4 for index 13).
- R6: With `avec_en_i` low, `fetch_data_o` is `mem_rdata_i` from the previous cycle, unchanged.
- R7: With `code_fetch_i` low (a data read), `fetch_data_o` is the previous `mem_rdata_i`, even at address 0x555.
- R8: Code fetches of any address other than 0x555, including the opcode at 0x553 and the page byte at 0x554, return the previous `mem_rdata_i` unchanged.
- R9: An acknowledge with no request pending clears the latched source: `src_sel_o` becomes 0, and later fetches of 0x555 pass memory data through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 14 | Request lines, bit 0 highest priority |
| irq_ack_i | input | 1 | Interrupt acknowledge; latches the winning source |
| avec_en_i | input | 1 | Autovector enable |
| code_fetch_i | input | 1 | Marks the current access as an instruction fetch |
| fetch_addr_i | input | 16 | Address of the current access |
| mem_rdata_i | input | 8 | Data returned by program memory |
| fetch_data_o | output | 8 | Registered data to the processor, possibly substituted |
| irq_any_o | output | 1 | Registered OR of all requests |
| src_sel_o | output | 4 | Registered latched source index, 0..13 |

## Verification
A wrong latched source shows on `src_sel_o` one cycle after the faulty edge. It also shows on `fetch_data_o` as the wrong jump-table byte on the next fetch of 0x555. A wrong priority chain appears only when two or more requests are set together at acknowledge time, so the stimulus combines several request bits. An address decode that is off by one, or that ignores the fetch strobe, corrupts a pass-through byte in the cycle after the access. Every cycle is therefore compared against a reference model.

// File: rtl/ivs_pkg.sv
package ivs_pkg;
  // Request bit positions, highest priority first
  typedef enum logic [3:0] {
    SRC_PROG_E2  = 4'd0,  SRC_PROG_E4  = 4'd1,  SRC_PROG_E6  = 4'd2,  SRC_PROG_E8  = 4'd3,
    SRC_EMPTY_E2 = 4'd4,  SRC_EMPTY_E4 = 4'd5,  SRC_EMPTY_E6 = 4'd6,  SRC_EMPTY_E8 = 4'd7,
    SRC_FULL_E2  = 4'd8,  SRC_FULL_E4  = 4'd9,  SRC_FULL_E6  = 4'd10, SRC_FULL_E8  = 4'd11,
    SRC_WAVE_DONE = 4'd12, SRC_WAVE_EVT = 4'd13
  } src_e;

  localparam int unsigned DEF_SRC_N     = 14;
  localparam int unsigned DEF_STUB_BASE = 32'h553;  // jump opcode location
  localparam int unsigned DEF_VEC_BASE  = 32'h80;
  localparam int unsigned DEF_VEC_STEP  = 4;
endpackage

// File: rtl/ivs_prio_enc.sv
module ivs_prio_enc #(
  parameter int unsigned SRC_N = 14,
  localparam int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  logic [SRC_N-1:0] higher;  // some higher-priority bit is set
  logic [SRC_N-1:0] hit;

  assign higher[0] = 1'b0;
  for (genvar g = 1; g < SRC_N; g++) begin : g_chain
    assign higher[g] = higher[g-1] | req[g-1];
  end
  assign hit = req & ~higher;
  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < SRC_N; i++)
      if (hit[i]) idx = idx | IDX_W'(i);
  end
endmodule

// File: rtl/ivs_src_latch.sv
module ivs_src_latch #(
  parameter int unsigned SRC_N = 14,
  localparam int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack,
  input  logic             any,
  input  logic [IDX_W-1:0] win,
  output logic             lat_vld,
  output logic [IDX_W-1:0] lat_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lat_vld <= 1'b0;
      lat_idx <= '0;
    end else if (ack) begin
      lat_vld <= any;
      lat_idx <= any ? win : '0;
    end
  end
endmodule

// File: rtl/ivs_fetch_mux.sv
module ivs_fetch_mux #(
  parameter int unsigned SRC_N     = 14,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STUB_BASE = 32'h553,
  parameter int unsigned VEC_BASE  = 32'h80,
  parameter int unsigned VEC_STEP  = 4,
  localparam int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rdata,
  input  logic              vld,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] fdata
);
  // low target byte sits two bytes after the opcode
  localparam logic [ADDR_W-1:0] SLOT = ADDR_W'(STUB_BASE + 2);
  localparam logic [DATA_W-1:0] VB   = DATA_W'(VEC_BASE);
  localparam logic [DATA_W-1:0] VS   = DATA_W'(VEC_STEP);

  logic [DATA_W-1:0] vec;
  logic              take;

  assign vec  = VB + VS * DATA_W'(idx);
  assign take = fetch && en && vld && (addr == SLOT);

  always_ff @(posedge clk) begin
    if (rst) fdata <= '0;
    else     fdata <= take ? vec : rdata;
  end
endmodule

// File: rtl/irq_vector_splicer.sv
module irq_vector_splicer #(
  parameter int unsigned SRC_N     = ivs_pkg::DEF_SRC_N,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STUB_BASE = ivs_pkg::DEF_STUB_BASE,
  parameter int unsigned VEC_BASE  = ivs_pkg::DEF_VEC_BASE,
  parameter int unsigned VEC_STEP  = ivs_pkg::DEF_VEC_STEP,
  localparam int unsigned IDX_W = $clog2(SRC_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  irq_req_i,
  input  logic              irq_ack_i,
  input  logic              avec_en_i,
  input  logic              code_fetch_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] fetch_data_o,
  output logic              irq_any_o,
  output logic [IDX_W-1:0]  src_sel_o
);
  logic             any_c;
  logic [IDX_W-1:0] win_c;
  logic             lat_vld;
  logic [IDX_W-1:0] lat_idx;

  ivs_prio_enc #(.SRC_N(SRC_N)) u_prio (
    .req(irq_req_i), .any(any_c), .idx(win_c)
  );

  ivs_src_latch #(.SRC_N(SRC_N)) u_lat (
    .clk(clk), .rst(rst), .ack(irq_ack_i), .any(any_c), .win(win_c),
    .lat_vld(lat_vld), .lat_idx(lat_idx)
  );

  ivs_fetch_mux #(
    .SRC_N(SRC_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STUB_BASE(STUB_BASE), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_mux (
    .clk(clk), .rst(rst), .fetch(code_fetch_i), .en(avec_en_i),
    .addr(fetch_addr_i), .rdata(mem_rdata_i), .vld(lat_vld), .idx(lat_idx),
    .fdata(fetch_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_any_o <= 1'b0;
    else     irq_any_o <= any_c;
  end

  assign src_sel_o = lat_idx;
endmodule

// File: rtl/irq_vector_splicer_chk.sv
module irq_vector_splicer_chk #(
  parameter int unsigned SRC_N  = 14,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(SRC_N)
) (
  input logic              clk,
  input logic              rst,
  input logic [SRC_N-1:0]  irq_req_i,
  input logic              irq_ack_i,
  input logic              avec_en_i,
  input logic              code_fetch_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic [DATA_W-1:0] mem_rdata_i,
  input logic [DATA_W-1:0] fetch_data_o,
  input logic              irq_any_o,
  input logic [IDX_W-1:0]  src_sel_o
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (fetch_data_o == '0 && !irq_any_o && src_sel_o == '0));

  a_r2_irq_or: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (irq_any_o == $past(|irq_req_i)));

  a_r3_index_range: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_req_i[0]) |=> (src_sel_o == '0));

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !irq_ack_i |=> $stable(src_sel_o));

  a_r6_disabled_pass: assert property (@(posedge clk) disable iff (rst)
    !avec_en_i |=> (fetch_data_o == $past(mem_rdata_i)));

  a_r7_data_read_pass: assert property (@(posedge clk) disable iff (rst)
    !code_fetch_i |=> (fetch_data_o == $past(mem_rdata_i)));

  a_r9_empty_ack: assert property (@(posedge clk) disable iff (rst)
    (irq_ack_i && irq_req_i == '0) |=> (src_sel_o == '0));
endmodule

bind irq_vector_splicer irq_vector_splicer_chk #(
  .SRC_N(SRC_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_req_i(irq_req_i), .irq_ack_i(irq_ack_i),
  .avec_en_i(avec_en_i), .code_fetch_i(code_fetch_i), .fetch_addr_i(fetch_addr_i),
  .mem_rdata_i(mem_rdata_i), .fetch_data_o(fetch_data_o), .irq_any_o(irq_any_o),
  .src_sel_o(src_sel_o)
);

// File: tb/irq_vector_splicer_test.sv
module irq_vector_splicer_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [13:0] req;
  logic        ack, en, fetch;
  logic [15:0] addr;
  logic [7:0]  rdata;
  logic [7:0]  fdata;
  logic        irq;
  logic [3:0]  src;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  bit       m_vld = 0;
  int       m_src = 0;

  always #5 clk = ~clk;

  irq_vector_splicer uut (
    .clk(clk), .rst(rst), .irq_req_i(req), .irq_ack_i(ack), .avec_en_i(en),
    .code_fetch_i(fetch), .fetch_addr_i(addr), .mem_rdata_i(rdata),
    .fetch_data_o(fdata), .irq_any_o(irq), .src_sel_o(src)
  );

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [13:0] r, input bit a, input bit e, input bit f,
                      input logic [15:0] ad, input logic [7:0] rd, input string tag);
    int efd, eirq, first;
    @(negedge clk);
    req = r; ack = a; en = e; fetch = f; addr = ad; rdata = rd;
    efd  = (f && e && m_vld && ad == 16'h555) ? 8'h80 + 4 * m_src : rd;
    eirq = (r != 0);
    if (a) begin
      first = -1;
      for (int i = 13; i >= 0; i--) if (r[i]) first = i;
      m_vld = (first >= 0);
      m_src = m_vld ? first : 0;
    end
    @(posedge clk); #1;
    chk({tag, " data"}, fdata, efd);
    chk({tag, " irq R2"}, irq, eirq);
    chk({tag, " src"}, src, m_src);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; req = '0; ack = 0; en = 1; fetch = 1; addr = 16'h555; rdata = 8'h5A;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset data", fdata, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset src", src, 0);
    @(negedge clk); rst = 0;

    // R9: no latch yet, 0x555 passes through
    step(14'h0, 0, 1, 1, 16'h555, 8'h11, "R9 no-latch");
    // R3: several pending, lowest bit wins
    step(14'b10_0000_0010_0000, 1, 1, 0, 16'h0, 8'h00, "R3 ack multi");
    chk("R3 winner index", src, 5);
    // R8: stub opcode and page byte untouched
    step(14'h0, 0, 1, 1, 16'h553, 8'h02, "R8 opcode");
    step(14'h0, 0, 1, 1, 16'h554, 8'h17, "R8 page");
    step(14'h0, 0, 1, 1, 16'h555, 8'hEE, "R5 vector");
    chk("R5 vector idx5", fdata, 8'h94);
    // R4: new requests without ack do not change the latch
    step(14'h0001, 0, 1, 1, 16'h555, 8'hEE, "R4 hold");
    chk("R4 hold idx", src, 5);
    // R6 / R7
    step(14'h0, 0, 0, 1, 16'h555, 8'h33, "R6 disabled");
    step(14'h0, 0, 1, 0, 16'h555, 8'h44, "R7 data read");
    // R5 extremes
    step(14'h2000, 1, 1, 0, 16'h0, 8'h0, "R3 ack last");
    step(14'h0, 0, 1, 1, 16'h555, 8'h00, "R5 idx13");
    chk("R5 vector 0xB4", fdata, 8'hB4);
    step(14'h3FFF, 1, 1, 0, 16'h0, 8'h0, "R3 ack all");
    step(14'h0, 0, 1, 1, 16'h555, 8'h00, "R5 idx0");
    chk("R5 vector 0x80", fdata, 8'h80);
    // R9: empty ack clears
    step(14'h0, 1, 1, 0, 16'h0, 8'h0, "R9 empty ack");
    step(14'h0, 0, 1, 1, 16'h555, 8'h77, "R9 pass");
    // each single source
    for (int k = 0; k < 14; k++) begin
      step(14'(1 << k), 1, 1, 0, 16'h0, 8'h0, "R3 single");
      step(14'h0, 0, 1, 1, 16'h555, 8'h00, "R5 single");
    end
    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      logic [15:0] ra;
      int sel = $urandom_range(0, 5);
      ra = (sel < 3) ? 16'h553 + 16'(sel) : (sel == 3 ? 16'h556 : 16'($urandom));
      step(14'($urandom) & (($urandom_range(0, 2) == 0) ? 14'h0 : 14'h3FFF),
           ($urandom_range(0, 4) == 0), $urandom_range(0, 3) != 0,
           $urandom_range(0, 3) != 0, ra, 8'($urandom), "R5 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule